// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Controller

This block controls an array of one-time-programmable fuse words, held here as an internal word array. Software reaches it through a plain register bus with byte offsets. It places a fuse word index and a data word in their registers, then writes a command into the operation control register. The command runs one of three operations. A read fetches one logical fuse word. A program burns one logical fuse word. A sense copies the whole array into read-only shadow registers. The shadow registers start at offset 0x100, above the control registers.

Each logical word is held twice. A program burns the data into index N and also into index N+1, which is the redundant copy. A read returns the OR of those two entries. Fuse bits only go from 0 to 1.

A power-down flag is set at reset. A command is refused while that flag is stored as set. Two locks hold until reset. The burn lock refuses every later program command. The register lock ignores every later register write. A refused command starts nothing and raises an error flag. The next command that is accepted clears that flag.

Register offsets:
- OP_CTRL at 0x000
- WORD_SEL at 0x004
- RD_WORD at 0x008
- WR_WORD at 0x00C
- STROBE_LEN at 0x010
- BURN_LOCK at 0x014
- REG_LOCK at 0x018
- shadow word i at 0x100 + 4*i

Top module: `efuse_ctrl`

## Requirements
- R1: After reset, OP_CTRL reads 0x0400_0000 and STROBE_LEN reads 0x0000_00C0. RD_WORD, WR_WORD, BURN_LOCK, REG_LOCK and every shadow word read 0. In OP_CTRL, bit 31 is busy, bit 30 is error and bit 26 is power-down. The command field, bits [1:0], always reads 0.
- R2: A write to OP_CTRL loads bit 26 into the power-down flag. Its bits [1:0] give the command: 1 is read, 2 is program, 3 is sense. A command is refused if power-down was set before that write, even when the same write clears it. A refused command sets the error flag and the block does not go busy.
- R3: A program of index N ORs WR_WORD into fuse entries N and N+1. Busy is high for STROBE_LEN cycles, or for 1 cycle when STROBE_LEN is 0.
- R4: Fuse bits are one-way. Programming a word again ORs the new data into it, and no stored bit ever returns to 0.
- R5: A read of index N loads RD_WORD with entry N ORed with entry N+1. Busy is high for exactly 1 cycle.
- R6: A sense copies all NW fuse entries into shadow words 0 to NW-1. Busy is high for NW cycles. Shadow words do not change from a program until the next sense.
- R7: Writing a value with bit 0 set to BURN_LOCK sets the burn lock. Writing 0 does not clear it. While the lock is set, program commands are refused with the error flag, and read commands are still accepted.
- R8: Writing a value with bit 0 set to REG_LOCK sets the register lock. After that, no register write takes effect. A command written to OP_CTRL is refused and sets the error flag.
- R9: A command written while busy is refused and sets the error flag. The operation already running completes unchanged.
- R10: A read or program with WORD_SEL above NW-2 is refused with the error flag. With the default NW of 32, index 31 is refused.
- R11: An accepted command clears the error flag.
- R12: A write to OP_CTRL with a command field of 0 only updates power-down. It starts nothing and leaves the error flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe for this cycle |
| bus_addr | input | AW | Byte offset of the register access |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |

## Verification
Two pairs of actions can land in the same cycle. The first pair is clearing power-down and issuing a command: both arrive in one OP_CTRL write. The bench makes that write and expects the command to be refused, the error bit to be set and power-down to read back cleared. The second pair is a running program strobe and a new command. The bench writes a read command during a 20-cycle program. It then checks that the error flag is set, and that a later read returns the burned word at both the primary and the redundant entry.

// File: rtl/efc_pkg.sv
package efc_pkg;
    localparam int WORD_W = 32;

    localparam int OFF_OP_CTRL   = 'h000;
    localparam int OFF_WORD_SEL  = 'h004;
    localparam int OFF_RD_WORD   = 'h008;
    localparam int OFF_WR_WORD   = 'h00C;
    localparam int OFF_STROBE    = 'h010;
    localparam int OFF_BURN_LOCK = 'h014;
    localparam int OFF_REG_LOCK  = 'h018;
    localparam int OFF_SHADOW    = 'h100;

    localparam int BIT_PD   = 26;
    localparam int BIT_ERR  = 30;
    localparam int BIT_BUSY = 31;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_PROG  = 2'd2,
        CMD_SENSE = 2'd3
    } efc_cmd_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_PROG  = 2'd2,
        ENG_SENSE = 2'd3
    } efc_eng_e;
endpackage

// File: rtl/efc_fuse_array.sv
module efc_fuse_array #(
    parameter int NW = 32,
    parameter int IW = $clog2(NW)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IW-1:0]                rd_idx,
    output logic [efc_pkg::WORD_W-1:0]   rd_pri,
    output logic [efc_pkg::WORD_W-1:0]   rd_red,
    input  logic                         pgm_en,
    input  logic [IW-1:0]                pgm_idx,
    input  logic [efc_pkg::WORD_W-1:0]   pgm_data,
    output logic [NW*efc_pkg::WORD_W-1:0] bits_o
);
    localparam int W = efc_pkg::WORD_W;

    logic [NW-1:0][W-1:0] words_d, words_q;
    logic [NW-1:0]        hit;
    logic [IW-1:0]        rd_idx_nx;
    logic [IW-1:0]        pgm_idx_nx;

    assign rd_idx_nx  = rd_idx + IW'(1);
    assign pgm_idx_nx = pgm_idx + IW'(1);

    // One burn decode per entry: primary and redundant copy share the strobe
    for (genvar g = 0; g < NW; g++) begin : g_hit
        assign hit[g] = pgm_en && ((pgm_idx == IW'(g)) || (pgm_idx_nx == IW'(g)));
    end

    always_comb begin
        words_d = words_q;
        for (int i = 0; i < NW; i++) begin
            if (hit[i]) begin
                words_d[i] = words_q[i] | pgm_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign rd_pri = words_q[rd_idx];
    assign rd_red = words_q[rd_idx_nx];
    assign bits_o = words_q;
endmodule

// File: rtl/efc_shadow.sv
module efc_shadow #(
    parameter int NW = 32,
    parameter int IW = $clog2(NW)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IW-1:0]              wr_idx,
    input  logic [efc_pkg::WORD_W-1:0] wr_data,
    input  logic [IW-1:0]              rd_idx,
    output logic [efc_pkg::WORD_W-1:0] rd_data
);
    localparam int W = efc_pkg::WORD_W;

    logic [NW-1:0][W-1:0] shadow_d, shadow_q;

    for (genvar g = 0; g < NW; g++) begin : g_ent
        always_comb begin
            shadow_d[g] = shadow_q[g];
            if (we && (wr_idx == IW'(g))) begin
                shadow_d[g] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
        end else begin
            shadow_q <= shadow_d;
        end
    end

    assign rd_data = shadow_q[rd_idx];
endmodule

// File: rtl/efc_engine.sv
module efc_engine #(
    parameter int NW = 32,
    parameter int PW = 16,
    parameter int IW = $clog2(NW)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  efc_pkg::efc_cmd_e          cmd,
    input  logic [IW-1:0]              index,
    input  logic [efc_pkg::WORD_W-1:0] wdata,
    input  logic [PW-1:0]              pulse,
    output logic                       busy,
    output logic [IW-1:0]              arr_rd_idx,
    input  logic [efc_pkg::WORD_W-1:0] arr_rd_pri,
    input  logic [efc_pkg::WORD_W-1:0] arr_rd_red,
    output logic                       arr_pgm_en,
    output logic [IW-1:0]              arr_pgm_idx,
    output logic [efc_pkg::WORD_W-1:0] arr_pgm_data,
    output logic                       rd_we,
    output logic [efc_pkg::WORD_W-1:0] rd_word,
    output logic                       sh_we,
    output logic [IW-1:0]              sh_idx,
    output logic [efc_pkg::WORD_W-1:0] sh_data
);
    import efc_pkg::*;

    typedef struct packed {
        efc_eng_e          st;
        logic [IW-1:0]     idx;
        logic [WORD_W-1:0] data;
        logic [PW-1:0]     cnt;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d        = eng_q;
        arr_pgm_en   = 1'b0;
        rd_we        = 1'b0;
        sh_we        = 1'b0;
        arr_rd_idx   = eng_q.idx;
        arr_pgm_idx  = eng_q.idx;
        arr_pgm_data = eng_q.data;
        rd_word      = arr_rd_pri | arr_rd_red;
        sh_idx       = eng_q.idx;
        sh_data      = arr_rd_pri;

        case (eng_q.st)
            ENG_IDLE: begin
                if (start) begin
                    eng_d.idx  = index;
                    eng_d.data = wdata;
                    case (cmd)
                        CMD_READ: eng_d.st = ENG_READ;
                        CMD_PROG: begin
                            eng_d.st  = ENG_PROG;
                            eng_d.cnt = (pulse == '0) ? PW'(1) : pulse;
                        end
                        CMD_SENSE: begin
                            eng_d.st  = ENG_SENSE;
                            eng_d.idx = '0;
                        end
                        default: eng_d.st = ENG_IDLE;
                    endcase
                end
            end
            ENG_READ: begin
                rd_we    = 1'b1;
                eng_d.st = ENG_IDLE;
            end
            ENG_PROG: begin
                if (eng_q.cnt == PW'(1)) begin
                    arr_pgm_en = 1'b1;
                    eng_d.st   = ENG_IDLE;
                end else begin
                    eng_d.cnt = eng_q.cnt - PW'(1);
                end
            end
            ENG_SENSE: begin
                sh_we = 1'b1;
                if (eng_q.idx == IW'(NW - 1)) begin
                    eng_d.st = ENG_IDLE;
                end else begin
                    eng_d.idx = eng_q.idx + IW'(1);
                end
            end
            default: eng_d.st = ENG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ENG_IDLE, idx: '0, data: '0, cnt: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign busy = (eng_q.st != ENG_IDLE);
endmodule

// File: rtl/efuse_ctrl.sv
module efuse_ctrl #(
    parameter int NW        = 32,
    parameter int PW        = 16,
    parameter int AW        = 10,
    parameter int PULSE_RST = 192
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_we,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata
);
    import efc_pkg::*;

    localparam int IW      = $clog2(NW);
    localparam int MAX_IDX = NW - 2;
    localparam int SH_END  = OFF_SHADOW + 4 * NW;

    typedef struct packed {
        logic              pd;
        logic              err;
        logic              pgm_lock;
        logic              wr_lock;
        logic [IW-1:0]     idx;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] rdata;
        logic [PW-1:0]     pulse;
    } regs_t;

    regs_t regs_d, regs_q;

    logic              start;
    efc_cmd_e          cmd;
    logic              busy_w;
    logic [IW-1:0]     arr_rd_idx, arr_pgm_idx, sh_idx, sh_rd_idx;
    logic [WORD_W-1:0] arr_rd_pri, arr_rd_red, arr_pgm_data;
    logic [WORD_W-1:0] rd_word, sh_data, sh_rd_data;
    logic              arr_pgm_en, rd_we, sh_we;
    logic [NW*WORD_W-1:0] fuse_bits;
    logic              in_shadow;

    assign cmd = efc_cmd_e'(bus_wdata[1:0]);

    always_comb begin
        regs_d = regs_q;
        start  = 1'b0;
        if (rd_we) begin
            regs_d.rdata = rd_word;
        end
        if (bus_we && !regs_q.wr_lock) begin
            case (32'(bus_addr))
                OFF_OP_CTRL: begin
                    regs_d.pd = bus_wdata[BIT_PD];
                    if (cmd != CMD_NONE) begin
                        if (regs_q.pd || busy_w ||
                            ((cmd != CMD_SENSE) && (32'(regs_q.idx) > MAX_IDX)) ||
                            ((cmd == CMD_PROG) && regs_q.pgm_lock)) begin
                            regs_d.err = 1'b1;
                        end else begin
                            start      = 1'b1;
                            regs_d.err = 1'b0;
                        end
                    end
                end
                OFF_WORD_SEL:  regs_d.idx   = bus_wdata[IW-1:0];
                OFF_WR_WORD:   regs_d.wdata = bus_wdata;
                OFF_STROBE:    regs_d.pulse = bus_wdata[PW-1:0];
                OFF_BURN_LOCK: regs_d.pgm_lock = regs_q.pgm_lock | bus_wdata[0];
                OFF_REG_LOCK:  regs_d.wr_lock  = bus_wdata[0];
                default: ;
            endcase
        end else if (bus_we && (32'(bus_addr) == OFF_OP_CTRL) && (cmd != CMD_NONE)) begin
            regs_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{pd: 1'b1, err: 1'b0, pgm_lock: 1'b0, wr_lock: 1'b0,
                        idx: '0, wdata: '0, rdata: '0, pulse: PW'(PULSE_RST)};
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read side: control registers by exact offset, shadow window by range
    assign in_shadow = (32'(bus_addr) >= OFF_SHADOW) && (32'(bus_addr) < SH_END);
    assign sh_rd_idx = IW'((32'(bus_addr) - OFF_SHADOW) >> 2);

    always_comb begin
        bus_rdata = '0;
        if (in_shadow) begin
            bus_rdata = sh_rd_data;
        end else begin
            case (32'(bus_addr))
                OFF_OP_CTRL: begin
                    bus_rdata[BIT_BUSY] = busy_w;
                    bus_rdata[BIT_ERR]  = regs_q.err;
                    bus_rdata[BIT_PD]   = regs_q.pd;
                end
                OFF_WORD_SEL:  bus_rdata = 32'(regs_q.idx);
                OFF_RD_WORD:   bus_rdata = regs_q.rdata;
                OFF_WR_WORD:   bus_rdata = regs_q.wdata;
                OFF_STROBE:    bus_rdata = 32'(regs_q.pulse);
                OFF_BURN_LOCK: bus_rdata = 32'(regs_q.pgm_lock);
                OFF_REG_LOCK:  bus_rdata = 32'(regs_q.wr_lock);
                default:       bus_rdata = '0;
            endcase
        end
    end

    efc_engine #(.NW(NW), .PW(PW), .IW(IW)) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cmd          (cmd),
        .index        (regs_q.idx),
        .wdata        (regs_q.wdata),
        .pulse        (regs_q.pulse),
        .busy         (busy_w),
        .arr_rd_idx   (arr_rd_idx),
        .arr_rd_pri   (arr_rd_pri),
        .arr_rd_red   (arr_rd_red),
        .arr_pgm_en   (arr_pgm_en),
        .arr_pgm_idx  (arr_pgm_idx),
        .arr_pgm_data (arr_pgm_data),
        .rd_we        (rd_we),
        .rd_word      (rd_word),
        .sh_we        (sh_we),
        .sh_idx       (sh_idx),
        .sh_data      (sh_data)
    );

    efc_fuse_array #(.NW(NW), .IW(IW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (arr_rd_idx),
        .rd_pri   (arr_rd_pri),
        .rd_red   (arr_rd_red),
        .pgm_en   (arr_pgm_en),
        .pgm_idx  (arr_pgm_idx),
        .pgm_data (arr_pgm_data),
        .bits_o   (fuse_bits)
    );

    efc_shadow #(.NW(NW), .IW(IW)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (sh_we),
        .wr_idx  (sh_idx),
        .wr_data (sh_data),
        .rd_idx  (sh_rd_idx),
        .rd_data (sh_rd_data)
    );
endmodule

// File: rtl/efc_checks.sv
module efc_checks #(
    parameter int NW = 32,
    parameter int AW = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [AW-1:0]     bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              busy,
    input logic              pd,
    input logic              err,
    input logic              pgm_lock,
    input logic              wr_lock,
    input logic [31:0]       wdata_q,
    input logic [NW*32-1:0]  fuse_bits
);
    logic ctrl_cmd;
    assign ctrl_cmd = bus_we && (32'(bus_addr) == efc_pkg::OFF_OP_CTRL) && (bus_wdata[1:0] != 2'd0);

    // R2: power-down held with the engine idle keeps it idle
    p_pd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pd && !busy) |=> !busy);

    // R4: no fuse bit falls back to 0
    p_fuse_oneway_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fuse_bits & $past(fuse_bits)) == $past(fuse_bits)));

    // R7: burn lock holds and refuses programs
    p_burn_lock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_lock |=> pgm_lock);
    p_burn_lock_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_lock && ctrl_cmd && (bus_wdata[1:0] == 2'd2)) |=> err);

    // R8: register lock holds and freezes write data
    p_reg_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lock |=> wr_lock);
    p_reg_lock_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lock && bus_we) |=> $stable(wdata_q));

    // R9: command during busy is refused
    p_busy_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_cmd) |=> err);
endmodule

bind efuse_ctrl efc_checks #(.NW(NW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .busy      (busy_w),
    .pd        (regs_q.pd),
    .err       (regs_q.err),
    .pgm_lock  (regs_q.pgm_lock),
    .wr_lock   (regs_q.wr_lock),
    .wdata_q   (regs_q.wdata),
    .fuse_bits (fuse_bits)
);

// File: tb/efuse_ctrl_test.sv
`timescale 1ns/1ps
module efuse_ctrl_test;
    localparam int NW = 32;
    localparam int AW = 10;
    localparam logic [AW-1:0] A_CTRL = 10'h000, A_SEL = 10'h004, A_RD = 10'h008,
                              A_WR = 10'h00C, A_STB = 10'h010, A_BL = 10'h014,
                              A_RL = 10'h018;
    localparam int NV = 6;
    // {index[7:0], data[31:0], strobe[15:0]}
    localparam logic [55:0] VEC [NV] = '{
        {8'd3,  32'h0000_00F0, 16'd4},
        {8'd3,  32'h0000_0F0F, 16'd0},
        {8'd4,  32'hA5A5_0000, 16'd2},
        {8'd10, 32'h1234_5678, 16'd192},
        {8'd30, 32'h8000_0001, 16'd3},
        {8'd0,  32'hFFFF_FFFF, 16'd1}
    };

    logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;
    logic [31:0] model [NW];

    always #10 clk = ~clk;

    efuse_ctrl #(.NW(NW), .AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Called right after wr(): counts cycles with busy high
    task automatic busy_len(output int n);
        logic [31:0] c;
        n = 0;
        rd(A_CTRL, c);
        while (c[31] && n < 5000) begin
            n++;
            @(negedge clk);
            rd(A_CTRL, c);
        end
    endtask

    task automatic burn(input int idx, input logic [31:0] d);
        model[idx]     = model[idx] | d;
        model[idx + 1] = model[idx + 1] | d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int n;
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, r); check("R1 ctrl", r, 32'h0400_0000);
        rd(A_STB, r);  check("R1 strobe", r, 32'h0000_00C0);
        rd(A_RD, r);   check("R1 rdword", r, 32'h0);
        rd(A_BL, r);   check("R1 burnlock", r, 32'h0);
        rd(A_RL, r);   check("R1 reglock", r, 32'h0);
        rd(10'h114, r); check("R1 shadow5", r, 32'h0);

        // R2 command with power-down set; then clear-and-command in one write
        wr(A_CTRL, 32'h0400_0001); busy_len(n);
        check("R2 pd busy", 32'(n), 32'd0);
        rd(A_CTRL, r); check("R2 pd err", r, 32'h4400_0000);
        wr(A_CTRL, 32'h0000_0001); busy_len(n);
        check("R2 same-write busy", 32'(n), 32'd0);
        rd(A_CTRL, r); check("R2 same-write err", r, 32'h4000_0000);

        // R12 command field 0
        wr(A_CTRL, 32'h0000_0000); busy_len(n);
        check("R12 busy", 32'(n), 32'd0);
        rd(A_CTRL, r); check("R12 ctrl", r, 32'h4000_0000);

        // R3 R4 R5 R11 vector walk
        for (int v = 0; v < NV; v++) begin
            int idx;
            int p;
            idx = int'(VEC[v][55:48]);
            p   = int'(VEC[v][15:0]);
            wr(A_STB, 32'(VEC[v][15:0]));
            wr(A_SEL, 32'(idx));
            wr(A_WR, VEC[v][47:16]);
            wr(A_CTRL, 32'h2); busy_len(n);
            burn(idx, VEC[v][47:16]);
            check("R3 strobe len", 32'(n), (p == 0) ? 32'd1 : 32'(p));
            rd(A_CTRL, r); check("R11 err cleared", r, 32'h0);
            wr(A_CTRL, 32'h1); busy_len(n);
            check("R5 read len", 32'(n), 32'd1);
            rd(A_RD, r); check("R5 R4 read word", r, model[idx] | model[idx + 1]);
        end

        // R4 reprogram with zero leaves word
        wr(A_SEL, 32'd3); wr(A_WR, 32'h0); wr(A_CTRL, 32'h2); busy_len(n);
        wr(A_CTRL, 32'h1); busy_len(n);
        rd(A_RD, r); check("R4 no clear", r, model[3] | model[4]);

        // R6 shadow untouched before sense, then sense
        rd(10'h10C, r); check("R6 pre-sense", r, 32'h0);
        wr(A_CTRL, 32'h3); busy_len(n);
        check("R6 sense len", 32'(n), 32'(NW));
        for (int i = 0; i < NW; i++) begin
            rd(AW'(32'h100 + 4 * i), r);
            check("R6 shadow", r, model[i]);
        end

        // R10 index above NW-2, then R11 clear via accepted read
        wr(A_SEL, 32'd31); wr(A_CTRL, 32'h1); busy_len(n);
        check("R10 busy", 32'(n), 32'd0);
        rd(A_CTRL, r); check("R10 err", r, 32'h4000_0000);
        wr(A_SEL, 32'd5); wr(A_CTRL, 32'h1); busy_len(n);
        rd(A_CTRL, r); check("R11 clear", r, 32'h0);

        // R9 command during a running program
        wr(A_STB, 32'd20); wr(A_SEL, 32'd12); wr(A_WR, 32'h55);
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h1);
        busy_len(n);
        burn(12, 32'h55);
        rd(A_CTRL, r); check("R9 err", r, 32'h4000_0000);
        wr(A_CTRL, 32'h1); busy_len(n);
        rd(A_RD, r); check("R9 burned", r, model[12] | model[13]);

        // R7 burn lock
        wr(A_BL, 32'h1);
        wr(A_SEL, 32'd20); wr(A_WR, 32'hFF); wr(A_CTRL, 32'h2); busy_len(n);
        check("R7 prog refused", 32'(n), 32'd0);
        rd(A_CTRL, r); check("R7 err", r, 32'h4000_0000);
        wr(A_CTRL, 32'h1); busy_len(n);
        rd(A_RD, r); check("R7 word unburned", r, model[20] | model[21]);
        rd(A_CTRL, r); check("R7 read accepted", r, 32'h0);
        wr(A_BL, 32'h0);
        rd(A_BL, r); check("R7 sticky", r, 32'h1);

        // R8 register lock
        wr(A_RL, 32'h1);
        wr(A_WR, 32'hDEAD);
        rd(A_WR, r); check("R8 wr frozen", r, 32'hFF);
        wr(A_CTRL, 32'h0400_0000);
        rd(A_CTRL, r); check("R8 pd frozen", r, 32'h0);
        wr(A_CTRL, 32'h1); busy_len(n);
        check("R8 cmd busy", 32'(n), 32'd0);
        rd(A_CTRL, r); check("R8 cmd err", r, 32'h4000_0000);
        wr(A_RL, 32'h0);
        rd(A_RL, r); check("R8 sticky", r, 32'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule